// File: doc/BRIEF.md
# Invertible 4-Point Integer Transform Datapath

This block computes the four-point forward integer transform applied to rows or columns of 4x4 video residual blocks. Four 3-bit unsigned samples A, B, C and D become four 6-bit signed coefficients P, Q, R and S. A fifth signed output G is kept alongside them, and with it the mapping can be undone exactly. The arithmetic runs as a chain of add/double/subtract steps. In each step one operand is replaced by the pair sum, the other operand is doubled by a left shift, and the sum is subtracted from the doubled value. The word widths grow by one bit per stage, and unsigned and signed words are mixed along the way.

A direction input, sampled with each valid item, picks the forward or the inverse direction. In the inverse direction the block takes P, R, S and G and returns the original A to D by undoing the stages in reverse order. Q is not needed for the inverse because S and G already fix both pair differences. Both directions are pipelined through three registered stages. A new item can be accepted every clock, and the two directions may be interleaved freely.

Top module: `h264_xform`

## Requirements
- R1: In the forward direction, out_p equals A+B+C+D as a 6-bit two's complement value.
- R2: In the forward direction, out_r equals A-B-C+D as a 6-bit two's complement value.
- R3: In the forward direction, out_q equals 2A+B-C-2D as a 6-bit two's complement value.
- R4: In the forward direction, out_s equals A-2B+2C-D as a 6-bit two's complement value.
- R5: In the forward direction, out_g equals 2B-2C as a 6-bit two's complement value.
- R6: An item accepted at a rising edge with in_valid=1 shows up with out_valid=1 exactly three rising edges later. out_inv equals the in_inv it was accepted with, and items leave in the order they came in, one per clock.
- R7: In the inverse direction (in_inv=1), when in_p, in_r, in_s and in_g hold the forward outputs for samples A..D, out_a..out_d return A..D.
- R8: Forward result ports (out_p, out_q, out_r, out_s, out_g) keep their values in every cycle that does not deliver a forward result. Inverse result ports (out_a..out_d) keep their values in every cycle that does not deliver an inverse result.
- R9: While the synchronous active-high rst is sampled high, out_valid and all result ports are cleared to 0. Items in flight at that time never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An item is presented this cycle |
| in_inv | input | 1 | Direction of the item: 0 forward, 1 inverse |
| in_a | input | IN_W (3) | Forward sample A, unsigned |
| in_b | input | IN_W (3) | Forward sample B, unsigned |
| in_c | input | IN_W (3) | Forward sample C, unsigned |
| in_d | input | IN_W (3) | Forward sample D, unsigned |
| in_p | input | IN_W+3 (6) | Inverse operand P, signed |
| in_r | input | IN_W+3 (6) | Inverse operand R, signed |
| in_s | input | IN_W+3 (6) | Inverse operand S, signed |
| in_g | input | IN_W+3 (6) | Inverse operand G, signed |
| out_valid | output | 1 | A result leaves this cycle |
| out_inv | output | 1 | Direction of the leaving result |
| out_p | output | IN_W+3 (6) | Coefficient P |
| out_q | output | IN_W+3 (6) | Coefficient Q |
| out_r | output | IN_W+3 (6) | Coefficient R |
| out_s | output | IN_W+3 (6) | Coefficient S |
| out_g | output | IN_W+3 (6) | Auxiliary output G |
| out_a | output | IN_W (3) | Recovered sample A |
| out_b | output | IN_W (3) | Recovered sample B |
| out_c | output | IN_W (3) | Recovered sample C |
| out_d | output | IN_W (3) | Recovered sample D |

## Verification
The inverse direction only means something when it is fed words the forward direction actually produced, and such words cannot be chosen freely at the ports. The stimulus therefore first sweeps all 4096 sample combinations forward, keeps every P, R, S and G that comes out, and then feeds those words back in the inverse direction. A later mixed phase interleaves forward items, inverse items and idle cycles, so that each set of result ports is seen holding its value while the other direction's items pass through. A reset is also applied while items are still in the pipeline.

// File: rtl/xf_pkg.sv
package xf_pkg;

  typedef enum logic {
    XF_FWD = 1'b0,
    XF_INV = 1'b1
  } xf_dir_e;

endpackage

// File: rtl/xf_lift_step.sv
// One add/double/subtract step: the updated operand becomes the pair sum,
// the kept operand is doubled and the sum removed, leaving keep - upd.
module xf_lift_step #(
  parameter int W = 3
) (
  input  logic [W-1:0] keep_i,
  input  logic [W-1:0] upd_i,
  output logic [W:0]   sum_o,
  output logic [W:0]   diff_o
);

  always_comb begin
    sum_o  = {1'b0, keep_i} + {1'b0, upd_i};
    diff_o = {keep_i, 1'b0} - sum_o;
  end

endmodule

// File: rtl/xf_unlift_step.sv
// Undoes xf_lift_step: sum + diff = 2*keep, upd = sum - keep.
module xf_unlift_step #(
  parameter int W = 3
) (
  input  logic [W:0]   sum_i,
  input  logic [W:0]   diff_i,
  output logic [W-1:0] keep_o,
  output logic [W-1:0] upd_o
);

  logic [W+1:0] twice;
  logic         unused_bits;

  always_comb begin
    twice  = {1'b0, sum_i} + {diff_i[W], diff_i};
    keep_o = twice[W:1];
    upd_o  = sum_i[W-1:0] - keep_o;
  end

  assign unused_bits = ^{twice[W+1], twice[0], sum_i[W]};

endmodule

// File: rtl/xf_fwd_path.sv
// Forward direction: three registered stages, each advancing on its enable.
module xf_fwd_path #(
  parameter int IN_W = 3,
  localparam int W1 = IN_W + 1,
  localparam int W2 = IN_W + 2,
  localparam int OUT_W = IN_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       en_i,
  input  logic [IN_W-1:0]  a_i,
  input  logic [IN_W-1:0]  b_i,
  input  logic [IN_W-1:0]  c_i,
  input  logic [IN_W-1:0]  d_i,
  output logic [OUT_W-1:0] p_o,
  output logic [OUT_W-1:0] q_o,
  output logic [OUT_W-1:0] r_o,
  output logic [OUT_W-1:0] s_o,
  output logic [OUT_W-1:0] g_o
);

  localparam int NPAIR = 2;

  // Stage 1: pair 0 is (A kept, D updated), pair 1 is (B kept, C updated).
  logic [IN_W-1:0] keep1 [NPAIR];
  logic [IN_W-1:0] upd1  [NPAIR];
  logic [W1-1:0]   sum1  [NPAIR];
  logic [W1-1:0]   dif1  [NPAIR];
  logic [W1-1:0]   sum1_q [NPAIR];
  logic [W1-1:0]   dif1_q [NPAIR];

  assign keep1[0] = a_i;
  assign upd1[0]  = d_i;
  assign keep1[1] = b_i;
  assign upd1[1]  = c_i;

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    xf_lift_step #(.W(IN_W)) u_lift (
      .keep_i (keep1[k]),
      .upd_i  (upd1[k]),
      .sum_o  (sum1[k]),
      .diff_o (dif1[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NPAIR; k++) begin
        sum1_q[k] <= '0;
        dif1_q[k] <= '0;
      end
    end else if (en_i[0]) begin
      for (int k = 0; k < NPAIR; k++) begin
        sum1_q[k] <= sum1[k];
        dif1_q[k] <= dif1[k];
      end
    end
  end

  // Stage 2: same step on the two unsigned pair sums.
  logic [W2-1:0]    sum2, dif2;
  logic [OUT_W-1:0] p2_q, r2_q;
  logic [W1-1:0]    d1_q, d2_q;

  xf_lift_step #(.W(W1)) u_lift2 (
    .keep_i (sum1_q[0]),
    .upd_i  (sum1_q[1]),
    .sum_o  (sum2),
    .diff_o (dif2)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      p2_q <= '0;
      r2_q <= '0;
      d1_q <= '0;
      d2_q <= '0;
    end else if (en_i[1]) begin
      p2_q <= {{(OUT_W-W2){1'b0}}, sum2};
      r2_q <= {{(OUT_W-W2){dif2[W2-1]}}, dif2};
      d1_q <= dif1_q[0];
      d2_q <= dif1_q[1];
    end
  end

  // Stage 3: combine the two pair differences.
  logic [OUT_W-1:0] e1, e2, e2x2, q3, s3;
  logic             unused_bits;

  always_comb begin
    e1   = {{(OUT_W-W1){d1_q[W1-1]}}, d1_q};
    e2   = {{(OUT_W-W1){d2_q[W1-1]}}, d2_q};
    e2x2 = {e2[OUT_W-2:0], 1'b0};
    q3   = {e1[OUT_W-2:0], 1'b0} + e2;
    s3   = e1 - e2x2;
  end

  assign unused_bits = ^{e1[OUT_W-1], e2[OUT_W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      p_o <= '0;
      q_o <= '0;
      r_o <= '0;
      s_o <= '0;
      g_o <= '0;
    end else if (en_i[2]) begin
      p_o <= p2_q;
      q_o <= q3;
      r_o <= r2_q;
      s_o <= s3;
      g_o <= e2x2;
    end
  end

endmodule

// File: rtl/xf_inv_path.sv
// Inverse direction: undoes stage 3, then stage 2, then stage 1.
module xf_inv_path #(
  parameter int IN_W = 3,
  localparam int W1 = IN_W + 1,
  localparam int W2 = IN_W + 2,
  localparam int OUT_W = IN_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       en_i,
  input  logic [OUT_W-1:0] p_i,
  input  logic [OUT_W-1:0] r_i,
  input  logic [OUT_W-1:0] s_i,
  input  logic [OUT_W-1:0] g_i,
  output logic [IN_W-1:0]  a_o,
  output logic [IN_W-1:0]  b_o,
  output logic [IN_W-1:0]  c_o,
  output logic [IN_W-1:0]  d_o
);

  localparam int NPAIR = 2;

  // Undo stage 3: d2 = G/2, d1 = S + G.
  logic [OUT_W-1:0] sg_sum;
  logic [W1-1:0]    d1a_q, d2a_q;
  logic [W2-1:0]    pa_q, ra_q;
  logic             unused_bits;

  assign sg_sum = s_i + g_i;
  assign unused_bits = ^{p_i[OUT_W-1:W2], r_i[OUT_W-1:W2], g_i[OUT_W-1:W1+1],
                         g_i[0], sg_sum[OUT_W-1:W1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      d1a_q <= '0;
      d2a_q <= '0;
      pa_q  <= '0;
      ra_q  <= '0;
    end else if (en_i[0]) begin
      d1a_q <= sg_sum[W1-1:0];
      d2a_q <= g_i[W1:1];
      pa_q  <= p_i[W2-1:0];
      ra_q  <= r_i[W2-1:0];
    end
  end

  // Undo stage 2: recover the two pair sums from P and R.
  logic [W1-1:0] s1, s2;
  logic [W1-1:0] s1b_q, s2b_q, d1b_q, d2b_q;

  xf_unlift_step #(.W(W1)) u_unlift2 (
    .sum_i  (pa_q),
    .diff_i (ra_q),
    .keep_o (s1),
    .upd_o  (s2)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1b_q <= '0;
      s2b_q <= '0;
      d1b_q <= '0;
      d2b_q <= '0;
    end else if (en_i[1]) begin
      s1b_q <= s1;
      s2b_q <= s2;
      d1b_q <= d1a_q;
      d2b_q <= d2a_q;
    end
  end

  // Undo stage 1 on both pairs.
  logic [W1-1:0]   psum [NPAIR];
  logic [W1-1:0]   pdif [NPAIR];
  logic [IN_W-1:0] pkeep [NPAIR];
  logic [IN_W-1:0] pupd  [NPAIR];

  assign psum[0] = s1b_q;
  assign pdif[0] = d1b_q;
  assign psum[1] = s2b_q;
  assign pdif[1] = d2b_q;

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    xf_unlift_step #(.W(IN_W)) u_unlift (
      .sum_i  (psum[k]),
      .diff_i (pdif[k]),
      .keep_o (pkeep[k]),
      .upd_o  (pupd[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_o <= '0;
      b_o <= '0;
      c_o <= '0;
      d_o <= '0;
    end else if (en_i[2]) begin
      a_o <= pkeep[0];
      d_o <= pupd[0];
      b_o <= pkeep[1];
      c_o <= pupd[1];
    end
  end

endmodule

// File: rtl/h264_xform.sv
module h264_xform
  import xf_pkg::*;
#(
  parameter int IN_W = 3,
  localparam int OUT_W = IN_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_inv,
  input  logic [IN_W-1:0]  in_a,
  input  logic [IN_W-1:0]  in_b,
  input  logic [IN_W-1:0]  in_c,
  input  logic [IN_W-1:0]  in_d,
  input  logic [OUT_W-1:0] in_p,
  input  logic [OUT_W-1:0] in_r,
  input  logic [OUT_W-1:0] in_s,
  input  logic [OUT_W-1:0] in_g,
  output logic             out_valid,
  output logic             out_inv,
  output logic [OUT_W-1:0] out_p,
  output logic [OUT_W-1:0] out_q,
  output logic [OUT_W-1:0] out_r,
  output logic [OUT_W-1:0] out_s,
  output logic [OUT_W-1:0] out_g,
  output logic [IN_W-1:0]  out_a,
  output logic [IN_W-1:0]  out_b,
  output logic [IN_W-1:0]  out_c,
  output logic [IN_W-1:0]  out_d
);

  localparam int DEPTH = 3;

  xf_dir_e          in_dir;
  logic [DEPTH:1]   vld_q;
  xf_dir_e          dir_q [DEPTH+1];
  logic [DEPTH-1:0] fwd_en, inv_en;

  assign in_dir   = xf_dir_e'(in_inv);
  assign dir_q[0] = in_dir;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      vld_q <= {vld_q[DEPTH-1:1], in_valid};
    end
  end

  for (genvar k = 1; k <= DEPTH; k++) begin : g_dir
    always_ff @(posedge clk) begin
      if (rst) dir_q[k] <= XF_FWD;
      else     dir_q[k] <= dir_q[k-1];
    end
  end

  always_comb begin
    fwd_en[0] = in_valid && (in_dir == XF_FWD);
    inv_en[0] = in_valid && (in_dir == XF_INV);
    for (int k = 1; k < DEPTH; k++) begin
      fwd_en[k] = vld_q[k] && (dir_q[k] == XF_FWD);
      inv_en[k] = vld_q[k] && (dir_q[k] == XF_INV);
    end
  end

  assign out_valid = vld_q[DEPTH];
  assign out_inv   = (dir_q[DEPTH] == XF_INV);

  xf_fwd_path #(.IN_W(IN_W)) u_fwd (
    .clk  (clk),
    .rst  (rst),
    .en_i (fwd_en),
    .a_i  (in_a),
    .b_i  (in_b),
    .c_i  (in_c),
    .d_i  (in_d),
    .p_o  (out_p),
    .q_o  (out_q),
    .r_o  (out_r),
    .s_o  (out_s),
    .g_o  (out_g)
  );

  xf_inv_path #(.IN_W(IN_W)) u_inv (
    .clk  (clk),
    .rst  (rst),
    .en_i (inv_en),
    .p_i  (in_p),
    .r_i  (in_r),
    .s_i  (in_s),
    .g_i  (in_g),
    .a_o  (out_a),
    .b_o  (out_b),
    .c_o  (out_c),
    .d_o  (out_d)
  );

endmodule

// File: rtl/xf_xform_chk.sv
module xf_xform_chk #(
  parameter int IN_W = 3,
  parameter int OUT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_inv,
  input logic             out_valid,
  input logic             out_inv,
  input logic [OUT_W-1:0] out_p,
  input logic [OUT_W-1:0] out_q,
  input logic [OUT_W-1:0] out_r,
  input logic [OUT_W-1:0] out_s,
  input logic [OUT_W-1:0] out_g,
  input logic [IN_W-1:0]  out_a,
  input logic [IN_W-1:0]  out_b,
  input logic [IN_W-1:0]  out_c,
  input logic [IN_W-1:0]  out_d
);

  logic [1:0] since_rst;
  logic signed [OUT_W+3:0] lhs_qs, rhs_g;

  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= 2'd0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  always_comb begin
    lhs_qs = 2 * OUT_W'(10)'($signed(out_q)) - 4 * OUT_W'(10)'($signed(out_s));
    rhs_g  = 5 * OUT_W'(10)'($signed(out_g));
  end

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  assert_dir_R6: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && out_valid) |-> (out_inv == $past(in_inv, 3)));

  assert_flush_R9: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd3) |-> !out_valid);

  assert_hold_fwd_R8: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !(out_valid && !out_inv)) |->
      ($stable(out_p) && $stable(out_q) && $stable(out_r) && $stable(out_s) && $stable(out_g)));

  assert_hold_inv_R8: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !(out_valid && out_inv)) |->
      ($stable(out_a) && $stable(out_b) && $stable(out_c) && $stable(out_d)));

  // Q, S and G come from separate arithmetic: 2Q - 4S must equal 5G (R3, R4, R5).
  assert_qsg_link_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_inv) |-> (lhs_qs == rhs_g));

  // P and R differ by 2(B+C), so their low bits agree (R1, R2).
  assert_pr_parity_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_inv) |-> (out_p[0] == out_r[0]));

endmodule

bind h264_xform xf_xform_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_inv    (in_inv),
  .out_valid (out_valid),
  .out_inv   (out_inv),
  .out_p     (out_p),
  .out_q     (out_q),
  .out_r     (out_r),
  .out_s     (out_s),
  .out_g     (out_g),
  .out_a     (out_a),
  .out_b     (out_b),
  .out_c     (out_c),
  .out_d     (out_d)
);

// File: tb/sim_h264_xform.sv
module sim_h264_xform;

  localparam int CLK_NS = 10;
  localparam int IN_W   = 3;
  localparam int OUT_W  = IN_W + 3;
  localparam int NCOMB  = 1 << (4 * IN_W);
  localparam int MSK    = (1 << IN_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_inv = 1'b0;
  logic [IN_W-1:0]  in_a = '0, in_b = '0, in_c = '0, in_d = '0;
  logic [OUT_W-1:0] in_p = '0, in_r = '0, in_s = '0, in_g = '0;
  logic             out_valid, out_inv;
  logic [OUT_W-1:0] out_p, out_q, out_r, out_s, out_g;
  logic [IN_W-1:0]  out_a, out_b, out_c, out_d;

  h264_xform #(.IN_W(IN_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_inv(in_inv),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
    .in_p(in_p), .in_r(in_r), .in_s(in_s), .in_g(in_g),
    .out_valid(out_valid), .out_inv(out_inv),
    .out_p(out_p), .out_q(out_q), .out_r(out_r), .out_s(out_s), .out_g(out_g),
    .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d)
  );

  always #(CLK_NS / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct packed {
    logic        inv;
    logic [31:0] idx;
    logic [31:0] stamp;
  } sb_t;

  sb_t sbq[$];
  int  total = 0;
  int  bad = 0;

  logic [OUT_W-1:0] fp [NCOMB];
  logic [OUT_W-1:0] fr [NCOMB];
  logic [OUT_W-1:0] fs [NCOMB];
  logic [OUT_W-1:0] fg [NCOMB];

  logic [5*OUT_W-1:0] last_f = '0;
  logic [4*IN_W-1:0]  last_i = '0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sv(input logic [OUT_W-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic int smp(input int idx, input int k);
    return (idx >> (IN_W * (3 - k))) & MSK;
  endfunction

  task automatic send(input bit inv, input int idx);
    @(negedge clk);
    in_valid = 1'b1;
    in_inv   = inv;
    if (!inv) begin
      in_a = IN_W'(smp(idx, 0));
      in_b = IN_W'(smp(idx, 1));
      in_c = IN_W'(smp(idx, 2));
      in_d = IN_W'(smp(idx, 3));
      in_p = OUT_W'(idx * 7);
      in_r = OUT_W'(idx * 3);
      in_s = OUT_W'(idx);
      in_g = OUT_W'(idx * 5);
    end else begin
      in_p = fp[idx];
      in_r = fr[idx];
      in_s = fs[idx];
      in_g = fg[idx];
      in_a = IN_W'(idx);
      in_b = IN_W'(idx >> 1);
      in_c = IN_W'(idx >> 2);
      in_d = IN_W'(idx * 3);
    end
    sbq.push_back('{inv: inv, idx: 32'(idx), stamp: 32'(cyc)});
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    sbq.delete();
    repeat (2) @(negedge clk);
    #1;
    chk("R9", "out_valid in reset", int'(out_valid), 0);
    chk("R9", "fwd ports in reset", int'({out_p, out_q, out_r, out_s, out_g}), 0);
    chk("R9", "inv ports in reset", int'({out_a, out_b, out_c, out_d}), 0);
    rst = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    #1;
    if (rst) begin
      last_f = '0;
      last_i = '0;
    end else begin
      if (out_valid) begin
        if (sbq.size() == 0) begin
          chk("R6", "unexpected out_valid", 1, 0);
        end else begin
          sb_t it;
          int  a, b, c, d, ix;
          it = sbq.pop_front();
          ix = int'(it.idx);
          a = smp(ix, 0); b = smp(ix, 1); c = smp(ix, 2); d = smp(ix, 3);
          chk("R6", "latency", cyc - int'(it.stamp), 3);
          chk("R6", "direction", int'(out_inv), int'(it.inv));
          if (!it.inv) begin
            chk("R1", "P", sv(out_p), a + b + c + d);
            chk("R2", "R", sv(out_r), a - b - c + d);
            chk("R3", "Q", sv(out_q), 2*a + b - c - 2*d);
            chk("R4", "S", sv(out_s), a - 2*b + 2*c - d);
            chk("R5", "G", sv(out_g), 2*b - 2*c);
            fp[ix] = out_p; fr[ix] = out_r; fs[ix] = out_s; fg[ix] = out_g;
          end else begin
            chk("R7", "A", int'(out_a), a);
            chk("R7", "B", int'(out_b), b);
            chk("R7", "C", int'(out_c), c);
            chk("R7", "D", int'(out_d), d);
          end
        end
      end
      if (!(out_valid && !out_inv))
        chk("R8", "fwd ports hold", int'({out_p, out_q, out_r, out_s, out_g}), int'(last_f));
      if (!(out_valid && out_inv))
        chk("R8", "inv ports hold", int'({out_a, out_b, out_c, out_d}), int'(last_i));
      last_f = {out_p, out_q, out_r, out_s, out_g};
      last_i = {out_a, out_b, out_c, out_d};
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCOMB; i++) begin
      fp[i] = '0; fr[i] = '0; fs[i] = '0; fg[i] = '0;
    end
    // R9: reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R9", "out_valid after reset", int'(out_valid), 0);
    chk("R9", "fwd ports after reset", int'({out_p, out_q, out_r, out_s, out_g}), 0);
    chk("R9", "inv ports after reset", int'({out_a, out_b, out_c, out_d}), 0);
    @(negedge clk);
    rst = 1'b0;

    // R1..R5, R6: full forward sweep, back to back
    for (int i = 0; i < NCOMB; i++) send(1'b0, i);
    idle(6);

    // R7: full inverse sweep on the captured forward words
    for (int i = 0; i < NCOMB; i++) send(1'b1, i);
    idle(6);

    // R8: interleaved directions with idle gaps
    for (int i = 0; i < 300; i++) begin
      case (i % 5)
        0, 1: send(1'b0, (i * 37) % NCOMB);
        2, 4: send(1'b1, (i * 53) % NCOMB);
        default: idle(1);
      endcase
    end
    idle(6);

    // R9: reset with items in flight; none may appear afterwards
    send(1'b0, 12'h5A3);
    send(1'b1, 12'h0F0);
    do_reset();
    idle(6);
    send(1'b0, NCOMB - 1);
    send(1'b1, 0);
    idle(6);

    chk("R6", "all items delivered", sbq.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule